// File: doc/BRIEF.md
# Serial NOR Flash Slave Emulator

This block behaves like a small serial NOR flash device seen from its SPI pins. A host drives chip select, serial clock and MOSI in SPI mode 0 (clock idle low, data sampled on the rising edge, MSB first). The emulator answers on MISO, changing it after falling clock edges. The SPI pins are oversampled by the block's own clock, so the serial clock has to be well below the system clock. Every command starts with a one-byte opcode and takes effect as the transfer runs or when chip select is raised. Addresses are three bytes, sent most significant first.

Storage is an on-chip byte array. Its size is a parameter, and reset fills it with 0xFF, the erased value. The block holds a status byte. Bit 0 means an operation is in progress and bit 1 is the write-enable latch. Bits 2, 3, 4 and 7 are plain storage that a status write can set. A program, erase or status write takes a cycle count set by parameter. During that time the status shows the device as busy, and only status reads are answered. An erase also walks the chosen range one byte per clock. Sector and page sizes are parameters. The page defaults to 256 bytes. The default sector is scaled down so that a simulation array can hold it.

Top module: `nor_flash_emu`

## Requirements
- R1: After reset the status byte is 0x00, every array byte reads 0xFF, and MISO is 0 whenever chip select is high.
- R2: Opcode 0x06 sets status bit 1 (write-enable latch) and opcode 0x04 clears it. Either one takes effect when chip select rises.
- R3: Page program (0x02), sector erase (0xD8), bulk erase (0xC7) and status write (0x01) have no effect while status bit 1 is clear.
- R4: An accepted program, erase or status write sets status bit 0 from chip-select rise until its busy time ends. At that point bits 0 and 1 both clear.
- R5: Page program stores the AND of the old byte and the received byte. It can only clear bits.
- R6: During page program the low 8 address bits wrap within the 256-byte page. A byte sent after offset 0xFF lands at offset 0x00 of the same page.
- R7: While status bit 0 is set, any opcode other than 0x05 is ignored. MISO stays 0 for the rest of that transfer, and the command has no effect.
- R8: Read (0x03) returns the byte at the 24-bit address right after the address. Further clocked bytes come from consecutive addresses, crossing page boundaries.
- R9: Fast read (0x0B) expects one dummy byte after the address. Data starts with the byte that follows the dummy byte.
- R10: Sector erase writes 0xFF to every byte of the sector that holds the address (sector = SECTOR_BYTES, aligned). Bytes outside that sector keep their values.
- R11: Bulk erase writes 0xFF to the whole array.
- R12: Status write (0x01) copies data bits 7, 4, 3 and 2 into the status byte when chip select rises. Bits 0 and 1 are not written from the data.
- R13: Opcode 0xB9 enters power-down, where every opcode except 0xAB is ignored. Opcode 0xAB, followed by three dummy bytes, returns the signature byte SIG_CODE (default 0x13) in any state, and leaves power-down when chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when not selected |

## Verification
A pin edge passes through two synchronizer stages and one edge register. A received byte therefore reaches the command engine about four clocks after its eighth rising edge. The reply byte is loaded at the next falling edge, and MISO updates about four clocks after that edge. The bench holds each serial clock phase for eight system clocks and reads MISO just before raising the clock, so every bit has settled. Commands that act on chip-select rise take effect about four clocks after deselect. The bench waits sixteen clocks between transfers. Busy windows are checked by reading status at once, which is much sooner than the shortest busy time, and then by polling the status byte until bit 0 clears.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;
    typedef logic [7:0] byte_t;

    localparam byte_t OP_WREN = 8'h06;
    localparam byte_t OP_WRDI = 8'h04;
    localparam byte_t OP_RDSR = 8'h05;
    localparam byte_t OP_WRSR = 8'h01;
    localparam byte_t OP_READ = 8'h03;
    localparam byte_t OP_FAST = 8'h0B;
    localparam byte_t OP_PROG = 8'h02;
    localparam byte_t OP_SERA = 8'hD8;
    localparam byte_t OP_BERA = 8'hC7;
    localparam byte_t OP_DOWN = 8'hB9;
    localparam byte_t OP_WAKE = 8'hAB;

    // status bits a status write may change (7, 4, 3, 2)
    localparam byte_t SR_WRITABLE = 8'h9C;
    localparam byte_t ERASED      = 8'hFF;
endpackage

// File: rtl/nor_pin_sync.sv
module nor_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_n_s,
    output logic mosi_s
);
    // bundle order: {sck, cs_n, mosi}; idle value keeps chip deselected
    localparam logic [2:0] IDLE = 3'b010;

    logic [2:0] stg_q [STAGES];
    logic [1:0] prev_q;   // {sck, cs_n} one stage later

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= IDLE;
                else        stg_q[g] <= {sck, cs_n, mosi};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= IDLE;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b01;
        else        prev_q <= stg_q[STAGES-1][2:1];
    end

    assign cs_n_s   = stg_q[STAGES-1][1];
    assign mosi_s   = stg_q[STAGES-1][0];
    assign sck_rise =  stg_q[STAGES-1][2] & ~prev_q[1] & ~cs_n_s;
    assign sck_fall = ~stg_q[STAGES-1][2] &  prev_q[1] & ~cs_n_s;
    assign cs_rise  =  cs_n_s & ~prev_q[0];
endmodule

// File: rtl/nor_byte_shifter.sv
module nor_byte_shifter
    import nor_emu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel,
    input  logic  rise,
    input  logic  fall,
    input  logic  mosi_s,
    input  byte_t tx_byte,
    output logic  rx_valid,
    output byte_t rx_byte,
    output logic  miso
);
    typedef struct packed {
        logic [2:0] bit_cnt;
        byte_t      rx_sh;
        byte_t      tx_sh;
        logic       valid;
        byte_t      rx_out;
        logic       miso;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (!sel) begin
            d.bit_cnt = 3'd0;
            d.tx_sh   = 8'h00;
        end else if (rise) begin
            d.rx_sh   = {q.rx_sh[6:0], mosi_s};
            d.bit_cnt = q.bit_cnt + 3'd1;
            if (q.bit_cnt == 3'd7) begin
                d.valid  = 1'b1;
                d.rx_out = {q.rx_sh[6:0], mosi_s};
            end
        end else if (fall) begin
            // falling edge after a full byte presents the next reply byte
            if (q.bit_cnt == 3'd0) d.tx_sh = tx_byte;
            else                   d.tx_sh = {q.tx_sh[6:0], 1'b0};
        end
        d.miso = sel & d.tx_sh[7];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_valid = q.valid;
    assign rx_byte  = q.rx_out;
    assign miso     = q.miso;
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array
    import nor_emu_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic [AW-1:0] raddr,
    output byte_t         rdata
);
    byte_t mem_q [MEM_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= ERASED;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
    import nor_emu_pkg::*;
#(
    parameter int    MEM_BYTES    = 1024,
    parameter int    PAGE_BYTES   = 256,
    parameter int    SECTOR_BYTES = 512,
    parameter int    PROG_CYC     = 1500,
    parameter int    ERASE_CYC    = 1000,
    parameter int    WRSR_CYC     = 800,
    parameter byte_t SIG_CODE     = 8'h13,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  byte_t         rx_byte,
    input  logic          desel,
    input  byte_t         rdata,
    output byte_t         tx_byte,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output byte_t         mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic          wip,
    output logic          wel,
    output logic          sleep
);
    localparam int PW       = $clog2(PAGE_BYTES);
    localparam int MAX_A    = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int BUSY_MAX = (MAX_A > WRSR_CYC) ? MAX_A : WRSR_CYC;
    localparam int BW       = $clog2(BUSY_MAX + 1);
    localparam int LW       = $clog2(MEM_BYTES + 1);

    typedef struct packed {
        byte_t          op;
        logic [2:0]     idx;      // index of next byte in the transfer, saturates at 7
        logic           ign;
        logic [23:0]    addr;
        byte_t          tx;
        logic           wip;
        logic           wel;
        logic           sleep;
        byte_t          sr_keep;
        byte_t          sr_new;
        logic           sr_got;
        logic           pp_got;
        logic [BW-1:0]  busy;
        logic [AW-1:0]  er_ptr;
        logic [LW-1:0]  er_left;
    } eng_t;

    eng_t d, q;

    logic [23:0]   addr_in, a_cur;
    byte_t         status_now;
    logic          op_ign;
    logic [AW-1:0] sec_base;

    always_comb begin
        d          = q;
        mem_we     = 1'b0;
        mem_waddr  = '0;
        mem_wdata  = 8'h00;
        addr_in    = {q.addr[15:0], rx_byte};
        a_cur      = (q.idx == 3'd3) ? addr_in : q.addr;
        mem_raddr  = a_cur[AW-1:0];
        status_now = (q.sr_keep & SR_WRITABLE) | {6'b0, q.wel, q.wip};
        op_ign     = (q.wip && rx_byte != OP_RDSR) || (q.sleep && rx_byte != OP_WAKE);
        sec_base   = q.addr[AW-1:0] & ~(AW'(SECTOR_BYTES - 1));

        // busy engine: erase walk first, then remaining busy time
        if (q.wip) begin
            if (q.er_left != '0) begin
                mem_we    = 1'b1;
                mem_waddr = q.er_ptr;
                mem_wdata = ERASED;
                d.er_ptr  = q.er_ptr + 1'b1;
                d.er_left = q.er_left - 1'b1;
            end else if (q.busy != '0) begin
                d.busy = q.busy - 1'b1;
            end else begin
                d.wip = 1'b0;
                d.wel = 1'b0;
            end
        end

        if (rx_valid) begin
            d.tx = 8'h00;
            if (q.idx != 3'd7) d.idx = q.idx + 3'd1;
            if (q.idx >= 3'd1 && q.idx <= 3'd3) d.addr = addr_in;
            if (q.idx == 3'd0) begin
                d.op  = rx_byte;
                d.ign = op_ign;
                if (!op_ign && rx_byte == OP_RDSR) d.tx = status_now;
            end else if (!q.ign) begin
                case (q.op)
                    OP_RDSR: d.tx = status_now;
                    OP_WRSR: if (q.idx == 3'd1) begin
                        d.sr_new = rx_byte;
                        d.sr_got = 1'b1;
                    end
                    OP_READ: if (q.idx >= 3'd3) begin
                        d.tx   = rdata;
                        d.addr = a_cur + 24'd1;
                    end
                    OP_FAST: if (q.idx >= 3'd4) begin
                        d.tx   = rdata;
                        d.addr = q.addr + 24'd1;
                    end
                    OP_PROG: if (q.idx >= 3'd4 && q.wel) begin
                        mem_we    = 1'b1;
                        mem_waddr = q.addr[AW-1:0];
                        mem_wdata = rdata & rx_byte;
                        d.addr    = {q.addr[23:PW], q.addr[PW-1:0] + 1'b1};
                        d.pp_got  = 1'b1;
                    end
                    OP_WAKE: if (q.idx >= 3'd3) d.tx = SIG_CODE;
                    default: ;
                endcase
            end
        end

        if (desel) begin
            d.idx    = 3'd0;
            d.ign    = 1'b0;
            d.sr_got = 1'b0;
            d.pp_got = 1'b0;
            d.tx     = 8'h00;
            if (!q.ign && q.idx != 3'd0) begin
                case (q.op)
                    OP_WREN: d.wel = 1'b1;
                    OP_WRDI: d.wel = 1'b0;
                    OP_WRSR: if (q.wel && q.sr_got) begin
                        d.sr_keep = q.sr_new & SR_WRITABLE;
                        d.wip     = 1'b1;
                        d.busy    = BW'(WRSR_CYC);
                    end
                    OP_PROG: if (q.wel && q.pp_got) begin
                        d.wip  = 1'b1;
                        d.busy = BW'(PROG_CYC);
                    end
                    OP_SERA: if (q.wel && q.idx >= 3'd4) begin
                        d.wip     = 1'b1;
                        d.busy    = BW'(ERASE_CYC);
                        d.er_ptr  = sec_base;
                        d.er_left = LW'(SECTOR_BYTES);
                    end
                    OP_BERA: if (q.wel) begin
                        d.wip     = 1'b1;
                        d.busy    = BW'(ERASE_CYC);
                        d.er_ptr  = '0;
                        d.er_left = LW'(MEM_BYTES);
                    end
                    OP_DOWN: d.sleep = 1'b1;
                    OP_WAKE: d.sleep = 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_byte = q.tx;
    assign wip     = q.wip;
    assign wel     = q.wel;
    assign sleep   = q.sleep;
endmodule

// File: rtl/nor_flash_emu.sv
module nor_flash_emu
    import nor_emu_pkg::*;
#(
    parameter int    MEM_BYTES    = 1024,
    parameter int    PAGE_BYTES   = 256,
    parameter int    SECTOR_BYTES = 512,
    parameter int    PROG_CYC     = 1500,
    parameter int    ERASE_CYC    = 1000,
    parameter int    WRSR_CYC     = 800,
    parameter int    SYNC_STAGES  = 2,
    parameter byte_t SIG_CODE     = 8'h13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int AW = $clog2(MEM_BYTES);

    logic          sck_rise, sck_fall, cs_rise, cs_n_s, mosi_s;
    logic          rx_valid;
    byte_t         rx_byte, tx_byte, rdata, mem_wdata;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic          wip, wel, sleep;

    nor_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
        .cs_n_s(cs_n_s), .mosi_s(mosi_s)
    );

    nor_byte_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sel(~cs_n_s), .rise(sck_rise), .fall(sck_fall), .mosi_s(mosi_s),
        .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte), .miso(spi_miso)
    );

    nor_cmd_engine #(
        .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WRSR_CYC(WRSR_CYC), .SIG_CODE(SIG_CODE)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .desel(cs_rise), .rdata(rdata),
        .tx_byte(tx_byte), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_raddr(mem_raddr), .wip(wip), .wel(wel), .sleep(sleep)
    );

    nor_cell_array #(.MEM_BYTES(MEM_BYTES)) u_cells (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(rdata)
    );
endmodule

// File: rtl/nor_flash_emu_chk.sv
module nor_flash_emu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_s,
    input logic       miso,
    input logic       wip,
    input logic       wel,
    input logic       sleep,
    input logic       mem_we,
    input logic [7:0] mem_wdata
);
    // R1: deselected device keeps MISO low
    a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !miso);

    // R4: end of busy time also drops the write-enable latch
    a_r4_done_drops_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    // R7: the latch cannot be set by a command issued while busy
    a_r7_no_latch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(wip));

    // R10: array writes made during busy time are erase writes
    a_r10_erase_writes_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wip) |-> (mem_wdata == 8'hFF));

    // R13: no array write while powered down
    a_r13_asleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !mem_we);

    // R13: power-down is never entered during busy time
    a_r13_no_sleep_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> !$past(wip));
endmodule

bind nor_flash_emu nor_flash_emu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .miso(spi_miso),
    .wip(wip), .wel(wel), .sleep(sleep), .mem_we(mem_we), .mem_wdata(mem_wdata)
);

// File: tb/nor_flash_emu_test.sv
`timescale 1ns/1ps
module nor_flash_emu_test;
    localparam int H   = 8;
    localparam int GAP = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] rbuf [8];
    logic [7:0] wbuf [4];

    always #10 clk = ~clk;

    nor_flash_emu uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = t[i];
            repeat (H) @(negedge clk);
            r[i] = miso;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic desel();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic put_addr(input logic [23:0] a);
        logic [7:0] r;
        xfer(a[23:16], r);
        xfer(a[15:8], r);
        xfer(a[7:0], r);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel();
        xfer(op, r);
        desel();
    endtask

    task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        sel();
        xfer(op, r);
        put_addr(a);
        desel();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] r;
        sel();
        xfer(8'h05, r);
        xfer(8'h00, s);
        desel();
    endtask

    task automatic read_n(input logic fast, input logic [23:0] a, input int n);
        logic [7:0] r;
        sel();
        xfer(fast ? 8'h0B : 8'h03, r);
        put_addr(a);
        if (fast) xfer(8'h00, r);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        desel();
    endtask

    task automatic prog(input logic [23:0] a, input int n);
        logic [7:0] r;
        sel();
        xfer(8'h02, r);
        put_addr(a);
        for (int i = 0; i < n; i++) xfer(wbuf[i], r);
        desel();
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        s = 8'h01;
        for (int i = 0; i < 40 && s[0]; i++) rd_status(s);
        chk(req, {7'b0, s[0]}, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 miso idle", {7'b0, miso}, 8'h00);
        rd_status(s);
        chk("R1 status after reset", s, 8'h00);
        read_n(1'b0, 24'h000000, 1);
        chk("R1 first byte", rbuf[0], 8'hFF);
        read_n(1'b0, 24'h0003FF, 1);
        chk("R1 last byte", rbuf[0], 8'hFF);
    endtask

    task automatic t_signature();
        logic [7:0] r, sig;
        sel();
        xfer(8'hAB, r);
        put_addr(24'h0);
        xfer(8'h00, sig);
        desel();
        chk("R13 signature awake", sig, 8'h13);
    endtask

    task automatic t_latch();
        logic [7:0] s;
        cmd1(8'h06);
        rd_status(s);
        chk("R2 latch set", s, 8'h02);
        cmd1(8'h04);
        rd_status(s);
        chk("R2 latch cleared", s, 8'h00);
    endtask

    task automatic t_no_latch();
        logic [7:0] s;
        wbuf[0] = 8'h00;
        prog(24'h000040, 1);
        rd_status(s);
        chk("R3 program without latch not busy", s, 8'h00);
        read_n(1'b0, 24'h000040, 1);
        chk("R3 program without latch", rbuf[0], 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] s;
        cmd1(8'h06);
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        prog(24'h000010, 2);
        rd_status(s);
        chk("R4 busy and latch", s, 8'h03);
        read_n(1'b0, 24'h000010, 1);
        chk("R7 read ignored while busy", rbuf[0], 8'h00);
        wait_idle("R4 busy ends");
        rd_status(s);
        chk("R4 status after program", s, 8'h00);
        read_n(1'b0, 24'h000010, 3);
        chk("R8 byte 0", rbuf[0], 8'hA5);
        chk("R8 byte 1", rbuf[1], 8'h3C);
        chk("R8 byte 2", rbuf[2], 8'hFF);
        cmd1(8'h06);
        wbuf[0] = 8'h0F;
        prog(24'h000010, 1);
        wait_idle("R5 busy ends");
        read_n(1'b0, 24'h000010, 1);
        chk("R5 program ANDs", rbuf[0], 8'h05);
    endtask

    task automatic t_wrap();
        cmd1(8'h06);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        prog(24'h0001FE, 4);
        wait_idle("R6 busy ends");
        read_n(1'b0, 24'h0001FE, 4);
        chk("R8 stream 1FE", rbuf[0], 8'h11);
        chk("R8 stream 1FF", rbuf[1], 8'h22);
        chk("R8 stream crosses page 200", rbuf[2], 8'hFF);
        chk("R8 stream 201", rbuf[3], 8'hFF);
        read_n(1'b0, 24'h000100, 2);
        chk("R6 wrapped 100", rbuf[0], 8'h33);
        chk("R6 wrapped 101", rbuf[1], 8'h44);
    endtask

    task automatic t_fast();
        read_n(1'b1, 24'h0001FE, 2);
        chk("R9 fast byte 0", rbuf[0], 8'h11);
        chk("R9 fast byte 1", rbuf[1], 8'h22);
    endtask

    task automatic t_sector();
        cmd1(8'h06);
        wbuf[0] = 8'h5A;
        prog(24'h000300, 1);
        wait_idle("R10 setup program");
        cmd_addr(8'hD8, 24'h000100);
        read_n(1'b0, 24'h000100, 1);
        chk("R3 erase without latch", rbuf[0], 8'h33);
        cmd1(8'h06);
        cmd_addr(8'hD8, 24'h000150);
        wait_idle("R10 erase ends");
        read_n(1'b0, 24'h000010, 1);
        chk("R10 sector 010", rbuf[0], 8'hFF);
        read_n(1'b0, 24'h000100, 2);
        chk("R10 sector 100", rbuf[0], 8'hFF);
        chk("R10 sector 101", rbuf[1], 8'hFF);
        read_n(1'b0, 24'h0001FF, 1);
        chk("R10 sector 1FF", rbuf[0], 8'hFF);
        read_n(1'b0, 24'h000300, 1);
        chk("R10 other sector kept", rbuf[0], 8'h5A);
    endtask

    task automatic t_wrsr();
        logic [7:0] r, s;
        sel(); xfer(8'h01, r); xfer(8'hFF, r); desel();
        rd_status(s);
        chk("R3 status write without latch", s, 8'h00);
        cmd1(8'h06);
        sel(); xfer(8'h01, r); xfer(8'hFF, r); desel();
        wait_idle("R12 busy ends");
        rd_status(s);
        chk("R12 writable bits", s, 8'h9C);
        cmd1(8'h06);
        sel(); xfer(8'h01, r); xfer(8'h00, r); desel();
        wait_idle("R12 busy ends again");
        rd_status(s);
        chk("R12 bits cleared", s, 8'h00);
    endtask

    task automatic t_sleep();
        logic [7:0] r, s, sig;
        cmd1(8'hB9);
        read_n(1'b0, 24'h000300, 1);
        chk("R13 read ignored asleep", rbuf[0], 8'h00);
        cmd1(8'h06);
        sel();
        xfer(8'hAB, r);
        put_addr(24'h0);
        xfer(8'h00, sig);
        desel();
        chk("R13 signature wakes", sig, 8'h13);
        rd_status(s);
        chk("R13 latch not set while asleep", s, 8'h00);
        read_n(1'b0, 24'h000300, 1);
        chk("R13 read after wake", rbuf[0], 8'h5A);
    endtask

    task automatic t_bulk();
        cmd1(8'hC7);
        read_n(1'b0, 24'h000300, 1);
        chk("R3 bulk erase without latch", rbuf[0], 8'h5A);
        cmd1(8'h06);
        cmd1(8'hC7);
        cmd1(8'hB9);
        wait_idle("R11 erase ends");
        read_n(1'b0, 24'h000300, 1);
        chk("R11 bulk erased and R7 power-down ignored", rbuf[0], 8'hFF);
        read_n(1'b0, 24'h0001FE, 1);
        chk("R11 bulk erased low", rbuf[0], 8'hFF);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_signature();
        t_latch();
        t_no_latch();
        t_program();
        t_wrap();
        t_fast();
        t_sector();
        t_wrsr();
        t_sleep();
        t_bulk();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule